// File: doc/BRIEF.md
# Vector Store Address and Byte-Enable Generator

This block turns one vector-store operation into a single memory write request. For each accepted operation it works out the effective byte address of a 512-bit (64-byte) store and the per-byte write enables. When the addressing mode updates the base register, it also works out the new base value. The operation supplies these fields:

- a 2-bit addressing mode;
- a 32-bit base and a 32-bit stride;
- a signed 4-bit immediate that counts in whole vectors;
- a predicate flag with a 64-bit lane mask;
- the 512-bit data.

Operations enter on a valid/ready stream, and requests leave on a second valid/ready stream. An operation is taken when `in_valid` and `in_ready` are both high at a clock edge. Its request appears on the next cycle and stays, unchanged, until the memory side raises `req_ready`. `in_ready` is high whenever the output register is empty or is being emptied in the same cycle, so back-pressure passes straight through with one entry of storage. The base writeback pulses only in the cycle the request is accepted, so the register file sees exactly one update for each store that actually issues.

Top module: `vec_store_agu`

## Requirements
- R1: Mode 0 (offset form, `in_mode`=2'b00) requests address base + sign-extended `in_imm` × 64 and never raises `wb_en`.
- R2: Mode 1 (offset post-update, 2'b01) requests address base unchanged, and on acceptance raises `wb_en` with `wb_base` = base + sign-extended `in_imm` × 64.
- R3: Mode 2 (register form, 2'b10) requests address base + stride and never raises `wb_en`.
- R4: Mode 3 (register post-update, 2'b11) requests address base unchanged, and on acceptance raises `wb_en` with `wb_base` = base + stride. Bit 0 of the mode is the only bit that separates post-update from plain.
- R5: `in_imm` is two's complement. 4'b1000 gives an offset of −512 bytes, and 4'b0111 gives +448 bytes.
- R6: All address and base sums wrap modulo 2^32.
- R7: With `in_pred`=0, `req_be` is all ones and `req_data` equals `in_data` bit for bit.
- R8: With `in_pred`=1, `req_be` equals `in_mask`. Bit i of the mask enables byte lane i, which is `req_data[8i+7:8i]`.
- R9: `wb_en` is high only in a cycle where `req_valid` and `req_ready` are both high and the held request came from a post-update mode.
- R10: While `req_valid`=1 and `req_ready`=0, the request fields stay unchanged and `in_ready`=0. `in_ready` = !`req_valid` || `req_ready`.
- R11: After reset, `req_valid`=0, `wb_en`=0 and `in_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Store operation present |
| in_ready | output | 1 | Operation can be taken this cycle |
| in_mode | input | 2 | Addressing mode: bit1 = register source, bit0 = post-update |
| in_base | input | 32 | Base register value |
| in_stride | input | 32 | Stride register value |
| in_imm | input | 4 | Signed offset in vectors |
| in_pred | input | 1 | Predicated store |
| in_mask | input | 64 | Lane mask, one bit per byte |
| in_data | input | 512 | Store data |
| req_valid | output | 1 | Write request present |
| req_ready | input | 1 | Memory accepts the request |
| req_addr | output | 32 | Effective byte address |
| req_data | output | 512 | Write data |
| req_be | output | 64 | Byte write enables |
| wb_en | output | 1 | Base writeback strobe |
| wb_base | output | 32 | Updated base value |

## Verification
Every request field is due exactly one clock after its operation is accepted. `wb_en` and `in_ready` are combinational on the held request and on `req_ready` in the cycle the request is taken. The bench keeps a queue of expected requests, filled on acceptance and drained on hand-off. At each falling edge it compares the registered fields against the head of that queue. It then sets `req_ready` and, a moment later in the same half cycle, checks the combinational `in_ready` and `wb_en`. Directed extremes of the immediate, base values that wrap, and mask patterns come first. These are followed by a long stretch of random stimulus with random back-pressure.

// File: rtl/vst_pkg.sv
package vst_pkg;
  typedef enum logic [1:0] {
    MODE_OFS      = 2'b00,
    MODE_OFS_POST = 2'b01,
    MODE_REG      = 2'b10,
    MODE_REG_POST = 2'b11
  } vst_mode_e;

  function automatic logic mode_is_post(vst_mode_e m);
    return m[0];
  endfunction

  function automatic logic mode_uses_reg(vst_mode_e m);
    return m[1];
  endfunction
endpackage

// File: rtl/vst_addr_gen.sv
module vst_addr_gen #(
  parameter int ADDR_W = 32,
  parameter int IMM_W  = 4,
  parameter int SCALE_SH = 6
) (
  input  logic [1:0]        mode,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] stride,
  input  logic [IMM_W-1:0]  imm,
  output logic [ADDR_W-1:0] eff_addr,
  output logic [ADDR_W-1:0] next_base,
  output logic              post_upd
);
  import vst_pkg::*;

  localparam int EXT_W = ADDR_W - IMM_W - SCALE_SH;

  vst_mode_e   mode_q;
  logic [ADDR_W-1:0] imm_bytes;
  logic [ADDR_W-1:0] operand;
  logic [ADDR_W-1:0] sum;

  always_comb begin
    mode_q    = vst_mode_e'(mode);
    // signed vector count scaled to bytes
    imm_bytes = {{EXT_W{imm[IMM_W-1]}}, imm, {SCALE_SH{1'b0}}};
    operand   = mode_uses_reg(mode_q) ? stride : imm_bytes;
    sum       = base + operand;
    post_upd  = mode_is_post(mode_q);
    eff_addr  = post_upd ? base : sum;
    next_base = sum;
  end
endmodule

// File: rtl/vst_lane_enable.sv
module vst_lane_enable #(
  parameter int LANES = 64
) (
  input  logic             pred,
  input  logic [LANES-1:0] mask,
  output logic [LANES-1:0] be
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign be[i] = pred ? mask[i] : 1'b1;
  end
endmodule

// File: rtl/vst_out_stage.sv
module vst_out_stage #(
  parameter int ADDR_W = 32,
  parameter int LANES  = 64,
  parameter int DATA_W = 512
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              drain,
  input  logic [ADDR_W-1:0] d_addr,
  input  logic [DATA_W-1:0] d_data,
  input  logic [LANES-1:0]  d_be,
  input  logic [ADDR_W-1:0] d_wb,
  input  logic              d_post,
  output logic              q_valid,
  output logic [ADDR_W-1:0] q_addr,
  output logic [DATA_W-1:0] q_data,
  output logic [LANES-1:0]  q_be,
  output logic [ADDR_W-1:0] q_wb,
  output logic              q_post
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
    end else if (load) begin
      q_valid <= 1'b1;
    end else if (drain) begin
      q_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_addr <= '0;
      q_data <= '0;
      q_be   <= '0;
      q_wb   <= '0;
      q_post <= 1'b0;
    end else if (load) begin
      q_addr <= d_addr;
      q_data <= d_data;
      q_be   <= d_be;
      q_wb   <= d_wb;
      q_post <= d_post;
    end
  end
endmodule

// File: rtl/vec_store_agu.sv
module vec_store_agu #(
  parameter int ADDR_W = 32,
  parameter int LANES  = 64,
  parameter int LANE_W = 8,
  parameter int IMM_W  = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [1:0]                in_mode,
  input  logic [ADDR_W-1:0]         in_base,
  input  logic [ADDR_W-1:0]         in_stride,
  input  logic [IMM_W-1:0]          in_imm,
  input  logic                      in_pred,
  input  logic [LANES-1:0]          in_mask,
  input  logic [LANES*LANE_W-1:0]   in_data,
  output logic                      req_valid,
  input  logic                      req_ready,
  output logic [ADDR_W-1:0]         req_addr,
  output logic [LANES*LANE_W-1:0]   req_data,
  output logic [LANES-1:0]          req_be,
  output logic                      wb_en,
  output logic [ADDR_W-1:0]         wb_base
);
  localparam int DATA_W   = LANES * LANE_W;
  localparam int SCALE_SH = $clog2(LANES);

  logic [ADDR_W-1:0] ea;
  logic [ADDR_W-1:0] nb;
  logic              post;
  logic [LANES-1:0]  be;
  logic              held_post;
  logic              take;
  logic              hand_off;

  vst_addr_gen #(
    .ADDR_W(ADDR_W), .IMM_W(IMM_W), .SCALE_SH(SCALE_SH)
  ) u_addr (
    .mode(in_mode), .base(in_base), .stride(in_stride), .imm(in_imm),
    .eff_addr(ea), .next_base(nb), .post_upd(post)
  );

  vst_lane_enable #(.LANES(LANES)) u_be (
    .pred(in_pred), .mask(in_mask), .be(be)
  );

  assign hand_off = req_valid && req_ready;
  assign in_ready = !req_valid || req_ready;
  assign take     = in_valid && in_ready;

  vst_out_stage #(
    .ADDR_W(ADDR_W), .LANES(LANES), .DATA_W(DATA_W)
  ) u_out (
    .clk(clk), .rst_n(rst_n), .load(take), .drain(hand_off),
    .d_addr(ea), .d_data(in_data), .d_be(be), .d_wb(nb), .d_post(post),
    .q_valid(req_valid), .q_addr(req_addr), .q_data(req_data),
    .q_be(req_be), .q_wb(wb_base), .q_post(held_post)
  );

  assign wb_en = hand_off && held_post;
endmodule

// File: rtl/vec_store_agu_chk.sv
module vec_store_agu_chk #(
  parameter int ADDR_W = 32,
  parameter int LANES  = 64,
  parameter int DATA_W = 512
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [1:0]        in_mode,
  input logic [ADDR_W-1:0] in_base,
  input logic              in_pred,
  input logic [LANES-1:0]  in_mask,
  input logic [DATA_W-1:0] in_data,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic [DATA_W-1:0] req_data,
  input logic [LANES-1:0]  req_be,
  input logic              wb_en
);
  a_r9_wb_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> (req_valid && req_ready));

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=>
      (req_valid && $stable(req_addr) && $stable(req_be) && $stable(req_data)));

  a_r10_stall_blocks_input: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |-> !in_ready);

  a_r7_full_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !in_pred) |=> (req_be == {LANES{1'b1}} && req_data == $past(in_data)));

  a_r8_mask_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_pred) |=> (req_be == $past(in_mask)));

  a_r4_post_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_mode[0]) |=> (req_addr == $past(in_base)));
endmodule

bind vec_store_agu vec_store_agu_chk #(
  .ADDR_W(ADDR_W), .LANES(LANES), .DATA_W(LANES*LANE_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_mode(in_mode), .in_base(in_base), .in_pred(in_pred), .in_mask(in_mask),
  .in_data(in_data), .req_valid(req_valid), .req_ready(req_ready),
  .req_addr(req_addr), .req_data(req_data), .req_be(req_be), .wb_en(wb_en)
);

// File: tb/vec_store_agu_bench.sv
module vec_store_agu_bench;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [1:0]   in_mode = '0;
  logic [31:0]  in_base = '0;
  logic [31:0]  in_stride = '0;
  logic [3:0]   in_imm = '0;
  logic         in_pred = 1'b0;
  logic [63:0]  in_mask = '0;
  logic [511:0] in_data = '0;
  logic         req_valid;
  logic         req_ready = 1'b0;
  logic [31:0]  req_addr;
  logic [511:0] req_data;
  logic [63:0]  req_be;
  logic         wb_en;
  logic [31:0]  wb_base;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  typedef struct {
    logic [31:0]  addr;
    logic [511:0] data;
    logic [63:0]  be;
    logic         post;
    logic [31:0]  wb;
    string        tag;
  } exp_t;

  exp_t q[$];

  vec_store_agu u_vec_store_agu (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_mode(in_mode), .in_base(in_base), .in_stride(in_stride), .in_imm(in_imm),
    .in_pred(in_pred), .in_mask(in_mask), .in_data(in_data),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_data(req_data), .req_be(req_be), .wb_en(wb_en), .wb_base(wb_base)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d cycles expected<150000", cycles);
      finish_run();
    end
  end

  task automatic chk(bit ok, string tag, logic [511:0] act, logic [511:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one half-cycle of stimulus and checking, entered at a falling edge
  task automatic step(bit v, logic [1:0] m, logic [31:0] b, logic [31:0] s,
                      logic [3:0] im, bit p, logic [63:0] mk, logic [511:0] d,
                      bit rdy, string xtag);
    exp_t e;
    bit   exp_v;
    logic signed [31:0] ofs;
    @(negedge clk);
    exp_v = (q.size() > 0);
    chk(req_valid == exp_v, "R10 req_valid", 512'(req_valid), 512'(exp_v));
    if (exp_v && req_valid) begin
      e = q[0];
      chk(req_addr == e.addr, e.tag, 512'(req_addr), 512'(e.addr));
      chk(req_data == e.data, "R7 data", req_data, e.data);
      chk(req_be == e.be, "R8 be", 512'(req_be), 512'(e.be));
    end
    req_ready = rdy;
    #1;
    chk(in_ready == (!exp_v || rdy), "R10 in_ready", 512'(in_ready), 512'(!exp_v || rdy));
    chk(wb_en == (exp_v && rdy && e.post), "R9 wb_en", 512'(wb_en),
        512'(exp_v && rdy && e.post));
    if (exp_v && rdy && e.post)
      chk(wb_base == e.wb, "R2 R4 wb_base", 512'(wb_base), 512'(e.wb));
    if (exp_v && rdy) void'(q.pop_front());
    in_valid = v; in_mode = m; in_base = b; in_stride = s; in_imm = im;
    in_pred = p; in_mask = mk; in_data = d;
    if (v && in_ready) begin
      ofs = 32'($signed(im)) * 32'sd64;
      e.data = d;
      e.be   = p ? mk : '1;
      e.post = m[0];
      e.wb   = m[1] ? b + s : b + 32'(ofs);
      e.addr = m[0] ? b : e.wb;
      e.tag  = (xtag != "") ? xtag :
               (m == 2'd0) ? "R1 addr" : (m == 2'd1) ? "R2 addr" :
               (m == 2'd2) ? "R3 addr" : "R4 addr";
      q.push_back(e);
    end
  endtask

  function automatic logic [511:0] rnd_data();
    logic [511:0] r;
    for (int i = 0; i < 16; i++) r[i*32 +: 32] = $urandom;
    return r;
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(req_valid == 1'b0, "R11 req_valid", 512'(req_valid), 512'(0));
    chk(wb_en == 1'b0, "R11 wb_en", 512'(wb_en), 512'(0));
    rst_n = 1'b1;
    #1;
    chk(in_ready == 1'b1, "R11 in_ready", 512'(in_ready), 512'(1));

    // directed: each mode, immediate extremes, wrap, masks
    step(1, 2'd0, 32'h0000_1000, 32'h0, 4'h3, 0, '0, rnd_data(), 1, "R1 addr");
    step(1, 2'd1, 32'h0000_2000, 32'h0, 4'h2, 0, '0, rnd_data(), 1, "R2 addr");
    step(1, 2'd2, 32'h0000_3000, 32'h44, 4'h0, 0, '0, rnd_data(), 1, "R3 addr");
    step(1, 2'd3, 32'h0000_4000, 32'h80, 4'h0, 0, '0, rnd_data(), 1, "R4 addr");
    step(1, 2'd0, 32'h0000_1000, 32'h0, 4'h8, 0, '0, rnd_data(), 1, "R5 min imm");
    step(1, 2'd0, 32'h0000_1000, 32'h0, 4'h7, 0, '0, rnd_data(), 1, "R5 max imm");
    step(1, 2'd1, 32'h0000_0100, 32'h0, 4'h8, 0, '0, rnd_data(), 1, "R5 post min");
    step(1, 2'd0, 32'hFFFF_FFC0, 32'h0, 4'h1, 0, '0, rnd_data(), 1, "R6 wrap imm");
    step(1, 2'd3, 32'hFFFF_FF00, 32'h200, 4'h0, 0, '0, rnd_data(), 1, "R6 wrap post");
    step(1, 2'd2, 32'h0000_0010, 32'hFFFF_FFF0, 4'h0, 0, '0, rnd_data(), 1, "R6 wrap reg");
    step(1, 2'd0, 32'h0, 32'h0, 4'h0, 1, 64'hF0F0_0000_FFFF_0001, rnd_data(), 1, "R8 addr");
    step(1, 2'd0, 32'h0, 32'h0, 4'h0, 1, 64'h0, rnd_data(), 1, "R8 addr");
    step(1, 2'd3, 32'h40, 32'h40, 4'h0, 1, 64'h8000_0000_0000_0001, rnd_data(), 0, "");
    step(1, 2'd1, 32'h80, 32'h0, 4'h1, 0, '0, rnd_data(), 0, "");
    step(0, 2'd0, 32'h0, 32'h0, 4'h0, 0, '0, '0, 0, "");
    step(0, 2'd0, 32'h0, 32'h0, 4'h0, 0, '0, '0, 1, "");
    step(0, 2'd0, 32'h0, 32'h0, 4'h0, 0, '0, '0, 1, "");

    // random traffic with random back-pressure
    for (int n = 0; n < 3000; n++) begin
      step(($urandom % 4) != 0, 2'($urandom), $urandom, $urandom, 4'($urandom),
           1'($urandom), {$urandom, $urandom}, rnd_data(), ($urandom % 3) != 0, "");
    end
    for (int n = 0; n < 4; n++)
      step(0, 2'd0, 32'h0, 32'h0, 4'h0, 0, '0, '0, 1, "");
    finish_run();
  end
endmodule